// File: doc/BRIEF.md
# Burst Register Access over SPI

This block is a SPI slave that gives an external master read and write access to an on-chip bank of 16-bit registers. The chip-select, serial clock and data-in lines are brought into the system clock domain through synchronizers, and all framing is done on detected clock edges. The serial clock must therefore run well below the system clock: one SPI half period should span at least six system clock cycles.

A frame opens when chip select falls. The first 16 bits form a command word, sent MSB first. It carries a fixed key in its top five bits, a direction flag and a 10-bit start address. A frame whose key does not match is ignored until chip select falls again. In an accepted frame, 16-bit data words follow. The address pointer moves to the next register after each complete word. Once the pointer reaches the last implemented register it stays there: it does not wrap, and any later write data is dropped.

The serial data output has a separate output-enable pin, so that the tristate buffer can be placed at the pad. There is no stream interface at the block edge. The only data path is the serial line, and it has no back-pressure because the master owns the clock.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_miso_oe` is 0. Chip select going high ends a frame at any bit.
- R2: A command word whose bits [15:11] differ from 5'b11100 causes no register write, and `spi_miso_oe` stays 0 for the rest of that frame.
- R3: Bits are taken MSB first on SCLK rising edges. Command bit 10 selects the direction (1 = read, 0 = write). Command bits [9:0] give the start register address.
- R4: A register is written only when all 16 bits of a data word have arrived. A word cut short by chip select rising leaves the register unchanged.
- R5: After each complete data word, the pointer advances by one, so a burst of words reaches consecutive registers.
- R6: The last writable address is NREG-1 (63 by default). A word written at that address is stored, and later words in the same frame are dropped. Address 0 is never reached by wrapping.
- R7: On a read, the addressed register is driven MSB first on `spi_miso`, which changes after SCLK falling edges starting with the first falling edge after the command word. The next register follows every 16 bits, and at the top address the last register is sent again.
- R8: Addresses NREG and above read as zero, and writes to them have no effect.
- R9: Operation is the same whether SCLK idles low or high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |

## Verification
Each internal error shows up at the serial port within one word of a later read-back. A bit counter that is off by one rotates every word read back, so the very first word shows it. A pointer that steps wrongly appears in the second word of a burst. A pointer that wraps instead of saturating overwrites register 0, which a single-word read of that register exposes. A wrong key decode appears either as a stored value where zero is expected, or as the output enable rising during a rejected frame, which is visible on the first data bit.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int WORD_W = 16;
  localparam logic [4:0] CMD_KEY = 5'b11100;
  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_WR, ST_RD, ST_REJ} frame_st_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_act_o,
  output logic cs_fall_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic mosi_o
);
  // bit 2 = csn, bit 1 = sclk, bit 0 = mosi
  logic [2:0] pipe [STAGES];
  logic       csn_prev, sclk_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= 3'b100;
        else if (s == 0) pipe[s] <= {csn_i, sclk_i, mosi_i};
        else pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_prev  <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      csn_prev  <= pipe[STAGES-1][2];
      sclk_prev <= pipe[STAGES-1][1];
    end
  end

  assign cs_act_o    = !pipe[STAGES-1][2];
  assign cs_fall_o   = csn_prev && !pipe[STAGES-1][2];
  assign sclk_rise_o = !sclk_prev && pipe[STAGES-1][1];
  assign sclk_fall_o = sclk_prev && !pipe[STAGES-1][1];
  assign mosi_o      = pipe[STAGES-1][0];
endmodule

// File: rtl/spi_rb_frame.sv
module spi_rb_frame
  import spi_rb_pkg::*;
#(
  parameter int NREG = 64,
  parameter int AW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi,
  input  logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [WORD_W-1:0] wdata,
  output logic              miso,
  output logic              miso_oe
);
  localparam logic [AW-1:0] PMAX = AW'(NREG - 1);

  frame_st_t         st;
  logic [3:0]        cnt;
  logic [WORD_W-1:0] sh, tx, nxt;
  logic [AW-1:0]     ptr;
  logic              sat, load_q;

  assign nxt     = {sh[WORD_W-2:0], mosi};
  assign rd_addr = ptr;
  assign miso_oe = (st == ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      sat <= 1'b0; load_q <= 1'b0; we <= 1'b0; waddr <= '0;
      wdata <= '0; miso <= 1'b0;
    end else begin
      we     <= 1'b0;
      load_q <= 1'b0;
      if (load_q) tx <= rd_data;
      if (!cs_act) begin
        st <= ST_IDLE;
      end else if (cs_fall) begin
        st  <= ST_CMD;
        cnt <= '0;
      end else begin
        case (st)
          ST_CMD: if (sclk_rise) begin
            sh  <= nxt;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15) begin
              if (nxt[15:11] == CMD_KEY) begin
                ptr <= nxt[AW-1:0];
                sat <= 1'b0;
                if (nxt[10]) begin
                  st     <= ST_RD;
                  load_q <= 1'b1;
                end else begin
                  st <= ST_WR;
                end
              end else begin
                st <= ST_REJ;
              end
            end
          end
          ST_WR: if (sclk_rise) begin
            sh  <= nxt;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd15 && !sat) begin
              we    <= 1'b1;
              waddr <= ptr;
              wdata <= nxt;
              if (ptr >= PMAX) sat <= 1'b1;
              else ptr <= ptr + 1'b1;
            end
          end
          ST_RD: begin
            if (sclk_rise) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd15) begin
                if (ptr < PMAX) ptr <= ptr + 1'b1;
                load_q <= 1'b1;
              end
            end
            if (sclk_fall) begin
              miso <= tx[WORD_W-1];
              tx   <= {tx[WORD_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  ptr_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WR || st == ST_RD) && cs_act) |=> ptr >= $past(ptr));
  // R6
  ptr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WR || st == ST_RD) && ptr <= PMAX) |=> ptr <= PMAX);
  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REJ) |=> (!we && !miso_oe));
endmodule

// File: rtl/spi_rb_bank.sv
module spi_rb_bank
  import spi_rb_pkg::*;
#(
  parameter int NREG = 64,
  parameter int AW   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [WORD_W-1:0] regs [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs[g] <= '0;
        else if (we && int'(waddr) == g) regs[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = (int'(raddr) < NREG) ? regs[raddr[IW-1:0]] : '0;

  // R4
  single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int NREG      = 64,
  parameter int AW        = 10,
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_csn,
  input  logic spi_sclk,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic              cs_act, cs_fall, sclk_rise, sclk_fall, mosi_s;
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] wdata, rdata;

  spi_rb_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .csn_i(spi_csn), .sclk_i(spi_sclk),
    .mosi_i(spi_mosi), .cs_act_o(cs_act), .cs_fall_o(cs_fall),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .mosi_o(mosi_s)
  );

  spi_rb_frame #(.NREG(NREG), .AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
    .rd_data(rdata), .rd_addr(raddr), .we(we), .waddr(waddr),
    .wdata(wdata), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_rb_bank #(.NREG(NREG), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso_oe);
endmodule

// File: tb/sim_spi_regbank_slave.sv
`timescale 1ns/1ps
module sim_spi_regbank_slave;
  localparam int HALF = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  logic [15:0] txw [$];
  logic [15:0] got_q [$];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  bit          oe_any, oe_all;

  always #4 clk = ~clk;

  spi_regbank_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(oe)
  );

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cmd(bit rd, int addr);
    return {5'b11100, rd, 10'(addr)};
  endfunction

  task automatic expect_word(logic [15:0] d, string tag);
    exp_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  // driver: one frame of nbits from txw
  task automatic frame(int nbits, bit idle_hi, bit cap);
    logic [15:0] cw = '0;
    oe_any = 1'b0; oe_all = 1'b1;
    sclk = idle_hi; #40;
    csn = 1'b0; #100;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = txw[i/16][15-(i%16)];
      #HALF;
      if (i >= 16) begin
        oe_any |= oe; oe_all &= oe;
        cw[15-((i-16)%16)] = miso;
        if (cap && ((i-16)%16) == 15) got_q.push_back(cw);
      end
      sclk = 1'b1;
      #HALF;
    end
    sclk = idle_hi; #100;
    csn = 1'b1; #200;
    txw.delete();
  endtask

  task automatic rd_burst(int addr, int n, bit idle_hi);
    txw.push_back(cmd(1, addr));
    for (int k = 0; k < n; k++) txw.push_back(16'h0);
    frame(16 + 16*n, idle_hi, 1'b1);
  endtask

  // monitor: compare produced words against expected queue
  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [15:0] a, e; string t;
      a = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      check(a == e, t, a, e);
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #50 rst_n = 1'b1;
    #100;
    check(oe == 1'b0, "R1 reset oe", 16'(oe), 16'h0);

    // reg 0 marker, for the no-wrap check
    txw.push_back(cmd(0, 0)); txw.push_back(16'h1234);
    frame(32, 0, 0);

    // R3 R5 burst write then burst read
    txw.push_back(cmd(0, 3));
    txw.push_back(16'h00A1); txw.push_back(16'h00B2); txw.push_back(16'h00C3);
    frame(64, 0, 0);
    expect_word(16'h00A1, "R3 burst rd w0");
    expect_word(16'h00B2, "R5 burst rd w1");
    expect_word(16'h00C3, "R5 burst rd w2");
    rd_burst(3, 3, 0);
    check(oe_all == 1'b1, "R7 oe during read", 16'(oe_all), 16'h1);

    // R4 partial word dropped
    txw.push_back(cmd(0, 10)); txw.push_back(16'h5A5A); txw.push_back(16'hFFFF);
    frame(40, 0, 0);
    expect_word(16'h5A5A, "R4 full word kept");
    expect_word(16'h0000, "R4 partial word dropped");
    rd_burst(10, 2, 0);

    // R2 bad key write, then bad key read
    txw.push_back({5'b11000, 1'b0, 10'd20}); txw.push_back(16'hBEEF);
    frame(32, 0, 0);
    expect_word(16'h0000, "R2 bad key write ignored");
    rd_burst(20, 1, 0);
    txw.push_back({5'b11110, 1'b1, 10'd3}); txw.push_back(16'h0);
    frame(32, 0, 0);
    check(oe_any == 1'b0, "R2 bad key read oe", 16'(oe_any), 16'h0);

    // R6 R7 saturation at top, no wrap
    txw.push_back(cmd(0, 62));
    txw.push_back(16'h1111); txw.push_back(16'h2222);
    txw.push_back(16'h3333); txw.push_back(16'h4444);
    frame(80, 0, 0);
    expect_word(16'h1111, "R6 reg62");
    expect_word(16'h2222, "R6 reg63");
    expect_word(16'h2222, "R7 top repeats");
    rd_burst(62, 3, 0);
    expect_word(16'h1234, "R6 reg0 not wrapped");
    rd_burst(0, 1, 0);

    // R8 beyond bank
    txw.push_back(cmd(0, 100)); txw.push_back(16'hCAFE);
    frame(32, 0, 0);
    expect_word(16'h0000, "R8 beyond bank w0");
    expect_word(16'h0000, "R8 beyond bank w1");
    rd_burst(100, 2, 0);

    // R9 SCLK idles high
    txw.push_back(cmd(0, 5)); txw.push_back(16'h0F0F); txw.push_back(16'h8001);
    frame(48, 1, 0);
    expect_word(16'h0F0F, "R9 idle high w0");
    expect_word(16'h8001, "R9 idle high w1");
    rd_burst(5, 2, 1);

    // R1 oe low after frame end
    #200;
    check(oe == 1'b0, "R1 oe after frame", 16'(oe), 16'h0);

    repeat (10) @(posedge clk);
    while (exp_q.size() > 0) begin
      logic [15:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(1'b0, {t, " missing"}, 16'hxxxx, e);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule